// File: doc/BRIEF.md
# Serial Byte Receiver with Start-Bit Timeout

This block recovers bytes from an asynchronous serial line that rests high. Each frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit; there is no parity. The line is first brought into the clock domain through a two-stage synchronizer. A falling edge on the synchronized line starts a frame. The receiver then waits half a bit period to reach the centre of the start bit. From there it takes every later sample one whole bit period after the one before.

Reception is gated by an arm input. While arm is high and the receiver is idle, a wait window opens. If no falling edge is seen within a programmable number of clock cycles, the block raises a one-cycle timeout pulse and receives nothing. A completed frame gives the byte together with a one-cycle valid strobe when the stop bit is high. When the stop bit is low, a one-cycle framing-error pulse is raised in place of the strobe.

Top module: `uart_rx_tmo`

## Requirements
- R1: When rst_n is low at a clock edge, the receiver returns to the disarmed idle state, and rx_byte, rx_valid, timeout_err and frame_err are all 0 afterwards.
- R2: While arm is low and the receiver is idle, activity on serial_in produces no rx_valid, frame_err or timeout_err.
- R3: A frame is a 0 start bit, eight data bits with bit 0 first, then a stop bit. With a stop bit of 1, rx_byte holds the eight data bits and rx_valid pulses. For example, the line sequence 1,0,1,0,0,0,1,1 after the start bit yields 0xC5.
- R4: Sample timing is measured from the clock edge that first captures a falling serial_in (edge 0). With B = CLKS_PER_BIT and H = B/2, the start bit is sampled H cycles after the fall and each later bit B cycles after the previous sample. rx_valid is registered on edge H+2+9B, which allows for the two synchronizer stages.
- R5: A stop-bit sample of 0 gives a one-cycle frame_err pulse and no rx_valid. rx_byte still holds the eight sampled data bits.
- R6: If the line is high again at the start-bit centre sample, the receiver abandons the frame with no output and goes back to waiting for a start bit.
- R7: When the idle receiver samples arm high, a wait window opens. If no falling edge is detected, timeout_err is registered high on the TIMEOUT_CLKS-th edge after the opening edge. If arm stays high, a fresh window opens on the next edge, so the next pulse comes TIMEOUT_CLKS+1 edges later.
- R8: If arm drops during a wait window, the window closes without a timeout_err pulse.
- R9: rx_valid, frame_err and timeout_err are each at most one cycle wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| serial_in | input | 1 | Asynchronous serial line, idles high |
| arm | input | 1 | Opens the start-bit wait window while high |
| rx_byte | output | 8 | Received byte, bit 0 received first |
| rx_valid | output | 1 | One-cycle strobe: byte received with good stop bit |
| timeout_err | output | 1 | One-cycle pulse: no start bit within the window |
| frame_err | output | 1 | One-cycle pulse: stop bit sampled low |

## Verification
The assertions take for granted that arm and serial_in are held for whole clock cycles. They also assume that CLKS_PER_BIT is at least 4 and TIMEOUT_CLKS at least 1, so the half-bit offset and the window are never zero. The stimulus drives both inputs only at falling clock edges. It holds every line bit for exactly CLKS_PER_BIT cycles and drops arm soon after each frame, so a leftover window cannot expire into the next check. Random bytes with mostly good and sometimes bad stop bits are mixed with directed glitch, disarmed, cancelled-window and timeout cases.

// File: rtl/uart_rx_tmo_pkg.sv
package uart_rx_tmo_pkg;
    localparam int unsigned DATA_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter logic REST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [2:0] pipe_q;
    logic [2:0] pipe_d;

    always_comb begin
        pipe_d = {pipe_q[1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {3{REST_LEVEL}};
        else        pipe_q <= pipe_d;
    end

    assign level = pipe_q[1];
    assign fall  = pipe_q[2] & ~pipe_q[1];
endmodule

// File: rtl/rx_wait_timer.sv
module rx_wait_timer #(
    parameter int unsigned LIMIT = 1000,
    localparam int unsigned TW = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)     cnt_d = '0;
        else if (en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo
    import uart_rx_tmo_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 5208,
    parameter int unsigned TIMEOUT_CLKS = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       serial_in,
    input  logic       arm,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       timeout_err,
    output logic       frame_err
);
    localparam int unsigned HALF_BIT = CLKS_PER_BIT / 2;
    localparam int unsigned CW       = $clog2(CLKS_PER_BIT);
    localparam int unsigned IW       = $clog2(DATA_BITS);

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        cnt;
        logic [IW-1:0]        idx;
        logic [DATA_BITS-1:0] shreg;
        logic                 valid;
        logic                 ferr;
        logic                 tmo;
    } rx_regs_t;

    rx_regs_t q, d;
    logic line_lvl, line_fall, win_expired;

    rx_line_sync #(.REST_LEVEL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (serial_in),
        .level (line_lvl),
        .fall  (line_fall)
    );

    rx_wait_timer #(.LIMIT(TIMEOUT_CLKS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (q.state != ST_HUNT),
        .en      (q.state == ST_HUNT),
        .expired (win_expired)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.ferr  = 1'b0;
        d.tmo   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (arm) d.state = ST_HUNT;
            end
            ST_HUNT: begin
                if (line_fall) begin
                    d.state = ST_START;
                    d.cnt   = CW'(HALF_BIT - 1);
                end else if (win_expired) begin
                    d.tmo   = 1'b1;
                    d.state = ST_IDLE;
                end else if (!arm) begin
                    d.state = ST_IDLE;
                end
            end
            ST_START: begin
                if (q.cnt == '0) begin
                    if (!line_lvl) begin
                        d.state = ST_DATA;
                        d.cnt   = CW'(CLKS_PER_BIT - 1);
                        d.idx   = '0;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_DATA: begin
                if (q.cnt == '0) begin
                    d.shreg = {line_lvl, q.shreg[DATA_BITS-1:1]};
                    d.cnt   = CW'(CLKS_PER_BIT - 1);
                    if (q.idx == IW'(DATA_BITS - 1)) d.state = ST_STOP;
                    else                             d.idx   = q.idx + 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_STOP: begin
                if (q.cnt == '0) begin
                    d.valid = line_lvl;
                    d.ferr  = ~line_lvl;
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.idx   <= '0;
            q.shreg <= '0;
            q.valid <= 1'b0;
            q.ferr  <= 1'b0;
            q.tmo   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rx_byte     = q.shreg;
    assign rx_valid    = q.valid;
    assign timeout_err = q.tmo;
    assign frame_err   = q.ferr;

    p_disarmed_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && !arm) |=> (q.state == ST_IDLE && !rx_valid && !frame_err && !timeout_err));

    p_valid_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(q.state == ST_STOP));

    p_ferr_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(q.state == ST_STOP));

    p_tmo_from_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> $past(q.state == ST_HUNT && !line_fall));

    p_valid_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_tmo_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, frame_err, timeout_err}));
endmodule

// File: tb/uart_rx_tmo_tb_top.sv
`timescale 1ns/1ps
module uart_rx_tmo_tb_top;
    localparam int CPB  = 16;
    localparam int HALF = CPB / 2;
    localparam int TMO  = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_in = 1'b1;
    logic       arm = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, timeout_err, frame_err;

    int cyc = 0;
    int n_chk = 0, n_err = 0;
    int n_valid = 0, n_ferr = 0, n_tmo = 0, n_wide = 0, n_overlap = 0;
    int valid_stamp = 0, tmo_stamp = 0, prev_tmo_stamp = 0;
    logic [7:0] cap_byte = '0;
    logic prev_valid = 1'b0, prev_ferr = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_rx_tmo #(.CLKS_PER_BIT(CPB), .TIMEOUT_CLKS(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .arm(arm),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .timeout_err(timeout_err), .frame_err(frame_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin n_valid++; cap_byte = rx_byte; valid_stamp = cyc; end
            if (frame_err) begin n_ferr++; cap_byte = rx_byte; end
            if (timeout_err) begin n_tmo++; prev_tmo_stamp = tmo_stamp; tmo_stamp = cyc; end
            if ((rx_valid && prev_valid) || (frame_err && prev_ferr)) n_wide++;
            if (int'(rx_valid) + int'(frame_err) + int'(timeout_err) > 1) n_overlap++;
            prev_valid = rx_valid;
            prev_ferr  = frame_err;
        end
    end

    function automatic int exp_valid_stamp(int fall_cyc);
        return fall_cyc + 3 + HALF + 9 * CPB;
    endfunction

    task automatic check(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] b, logic stop_bit, output int fall_cyc);
        @(negedge clk);
        serial_in = 1'b0;
        fall_cyc = cyc;
        ticks(CPB);
        for (int i = 0; i < 8; i++) begin
            serial_in = b[i];
            ticks(CPB);
        end
        serial_in = stop_bit;
        ticks(CPB);
        serial_in = 1'b1;
    endtask

    task automatic run_frame(logic [7:0] b, logic stop_bit, logic armed, string req);
        int v0, f0, t0, fc;
        v0 = n_valid; f0 = n_ferr; t0 = n_tmo;
        arm = armed;
        ticks(3);
        send_frame(b, stop_bit, fc);
        ticks(CPB);
        arm = 1'b0;
        ticks(5);
        check(n_tmo - t0, 0, req);
        if (!armed) begin
            check(n_valid - v0, 0, req);
            check(n_ferr - f0, 0, req);
        end else if (stop_bit) begin
            check(n_valid - v0, 1, req);
            check(n_ferr - f0, 0, req);
            check(int'(cap_byte), int'(b), req);
            check(valid_stamp, exp_valid_stamp(fc), {req, " R4 timing"});
        end else begin
            check(n_valid - v0, 0, req);
            check(n_ferr - f0, 1, req);
            check(int'(cap_byte), int'(b), req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int arm_cyc, t0, v0, f0;
        void'($urandom(32'h5EED_0042));
        ticks(5);
        // R1 reset state
        check(int'(rx_byte), 0, "R1");
        check(int'(rx_valid), 0, "R1");
        check(int'(timeout_err), 0, "R1");
        check(int'(frame_err), 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        ticks(4);
        check(int'(rx_valid | frame_err | timeout_err), 0, "R1");

        // R3 directed 0xC5 and extremes
        run_frame(8'hC5, 1'b1, 1'b1, "R3");
        run_frame(8'h00, 1'b1, 1'b1, "R3");
        run_frame(8'hFF, 1'b1, 1'b1, "R3");
        // R5 bad stop bit
        run_frame(8'h3A, 1'b0, 1'b1, "R5");
        // R2 disarmed: frame ignored
        run_frame(8'h5A, 1'b1, 1'b0, "R2");

        // R6 glitch shorter than half a bit, then a good frame
        v0 = n_valid; f0 = n_ferr;
        arm = 1'b1;
        ticks(3);
        serial_in = 1'b0;
        ticks(3);
        serial_in = 1'b1;
        ticks(CPB * 2);
        check(n_valid - v0, 0, "R6");
        check(n_ferr - f0, 0, "R6");
        run_frame(8'h96, 1'b1, 1'b1, "R6");

        // R8 window cancelled
        t0 = n_tmo;
        arm = 1'b1;
        ticks(TMO / 2);
        arm = 1'b0;
        ticks(TMO * 2);
        check(n_tmo - t0, 0, "R8");

        // R7 timeout timing, then reopened window
        t0 = n_tmo;
        @(negedge clk);
        arm = 1'b1;
        arm_cyc = cyc;
        ticks(2 * TMO + 10);
        arm = 1'b0;
        ticks(5);
        check(n_tmo - t0, 2, "R7");
        check(prev_tmo_stamp, arm_cyc + TMO + 1, "R7");
        check(tmo_stamp - prev_tmo_stamp, TMO + 1, "R7");
        check(n_valid - v0, 1, "R7 no byte");

        // random frames
        for (int k = 0; k < 12; k++) begin
            logic [7:0] b;
            logic sb;
            b  = 8'($urandom);
            sb = ($urandom % 4) != 0;
            run_frame(b, sb, 1'b1, sb ? "R3" : "R5");
        end

        // R9 pulse width and exclusivity
        check(n_wide, 0, "R9");
        check(n_overlap, 0, "R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule